// File: doc/BRIEF.md
# Two-Master Bus Arbiter

This block decides which of two bus masters owns a shared synchronous bus. Each master raises its own request line and keeps it high for the whole of its transaction; the arbiter answers on a dedicated grant line per master. Only one grant is ever high. When the bus is free and both masters ask at once, master 0 wins.

Ownership is not preemptive. Once a master holds the grant, it keeps it for as long as its request stays high, whatever the other master does. When the owner lowers its request, the grant falls on the next clock. The bus then stays quiet for a configurable number of cycles (`IDLE_GAP`, at least one) before any new grant is issued, and a master that is still waiting then gets the bus. Grants come from a register, so a request sampled at a clock edge shows its grant in the cycle that follows that edge.

Top module: `two_master_arbiter`

## Requirements
- R1: While `rst_n` is sampled low at a clock edge, both grants are low in the cycle after that edge, whatever the requests are.
- R2: `gnt_m0` and `gnt_m1` are never high in the same cycle.
- R3: On a free bus with the quiet period over, a master whose request is the only one sampled high at an edge has its grant high in the next cycle.
- R4: On a free bus with the quiet period over, when both requests are sampled high at the same edge, `gnt_m0` rises and `gnt_m1` stays low.
- R5: While a master's grant is high and its request is sampled high, its grant stays high in the next cycle, even when the other master requests.
- R6: When the owner's request is sampled low at an edge, its grant is low in the next cycle.
- R7: After a grant falls, both grants stay low for exactly `IDLE_GAP` cycles if a request is pending; the grant then goes to the waiting master (to master 0 if both wait).
- R8: A grant only rises if the same master's request was high in the cycle before.
- R9: With neither request high, both grants stay low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_m0 | input | 1 | Bus request from master 0 (higher priority on a free bus) |
| req_m1 | input | 1 | Bus request from master 1 |
| gnt_m0 | output | 1 | Bus grant to master 0 |
| gnt_m1 | output | 1 | Bus grant to master 1 |

## Verification
The bench builds the arbiter with `IDLE_GAP` set to 2 instead of the default 1, so the quiet-period counter must really count down across more than one cycle rather than only being loaded and found at zero. With that value, a request pending during the gap is held off for two cycles, which makes a grant that fires one cycle early visible at the ports. The sequences cover a hand-over in each direction, a contention on a free bus, a one-cycle request pulse, a request by master 0 against an owning master 1, and a reset while a grant is held.

// File: rtl/arb_pkg.sv
// Package: shared types for the two-master arbiter.
// Assumes: exactly two masters; index 0 is the higher priority one.
package arb_pkg;

    // Who holds the bus at present.
    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_M0   = 2'd1,
        OWN_M1   = 2'd2
    } owner_e;

endpackage

// File: rtl/arb_pick.sv
// Module: arb_pick
// Chooses which master would win a free bus from the current requests.
// Assumes: fixed priority, master 0 above master 1; purely combinational.
module arb_pick
    import arb_pkg::*;
(
    input  logic   req_m0,
    input  logic   req_m1,
    output owner_e winner
);

    // Fixed-priority choice among the live requests.
    always_comb begin
        if (req_m0)
            winner = OWN_M0;
        else if (req_m1)
            winner = OWN_M1;
        else
            winner = OWN_NONE;
    end

endmodule

// File: rtl/arb_gap_timer.sv
// Module: arb_gap_timer
// Counts the quiet cycles that must pass after a release before a new grant.
// Assumes: IDLE_GAP >= 1; load is a one-cycle pulse in the release cycle.
module arb_gap_timer #(
    parameter int IDLE_GAP = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic ready
);

    localparam int CW = (IDLE_GAP > 1) ? $clog2(IDLE_GAP) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(IDLE_GAP - 1);

    logic [CW-1:0] cnt_q;

    // Load on release, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= RELOAD;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    // The bus may be handed out again once the count is spent.
    assign ready = (cnt_q == '0);

endmodule

// File: rtl/arb_owner_fsm.sv
// Module: arb_owner_fsm
// Tracks the current bus owner: grants a free bus, holds it while the
// owner requests, and frees it when the owner lets go.
// Assumes: the winner input already reflects the priority rule.
module arb_owner_fsm
    import arb_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   req_m0,
    input  logic   req_m1,
    input  owner_e winner,
    input  logic   gap_ready,
    output owner_e owner,
    output logic   release_now
);

    owner_e owner_q;
    owner_e owner_d;

    // Detect that the present owner has dropped its request.
    always_comb begin
        unique case (owner_q)
            OWN_M0:  release_now = !req_m0;
            OWN_M1:  release_now = !req_m1;
            default: release_now = 1'b0;
        endcase
    end

    // Next-owner decision.
    always_comb begin
        owner_d = owner_q;
        unique case (owner_q)
            OWN_NONE: if (gap_ready) owner_d = winner;
            OWN_M0:   if (release_now) owner_d = OWN_NONE;
            OWN_M1:   if (release_now) owner_d = OWN_NONE;
            default:  owner_d = OWN_NONE;
        endcase
    end

    // Owner register with synchronous reset to a free bus.
    always_ff @(posedge clk) begin
        if (!rst_n)
            owner_q <= OWN_NONE;
        else
            owner_q <= owner_d;
    end

    assign owner = owner_q;

endmodule

// File: rtl/two_master_arbiter.sv
// Module: two_master_arbiter (top)
// Central arbiter for two masters with separate request and grant lines.
// Non-preemptive; master 0 wins a free bus; IDLE_GAP quiet cycles after
// every release. Assumes requests are synchronous to clk.
module two_master_arbiter
    import arb_pkg::*;
#(
    parameter int IDLE_GAP = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_m0,
    input  logic req_m1,
    output logic gnt_m0,
    output logic gnt_m1
);

    owner_e winner;
    owner_e owner;
    logic   release_now;
    logic   gap_ready;

    // Elaboration-time guard on the parameter.
    if (IDLE_GAP < 1) begin : g_bad_gap
        $error("IDLE_GAP must be at least 1");
    end

    arb_pick u_pick (
        .req_m0 (req_m0),
        .req_m1 (req_m1),
        .winner (winner)
    );

    arb_gap_timer #(.IDLE_GAP(IDLE_GAP)) u_gap (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (release_now),
        .ready (gap_ready)
    );

    arb_owner_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_m0      (req_m0),
        .req_m1      (req_m1),
        .winner      (winner),
        .gap_ready   (gap_ready),
        .owner       (owner),
        .release_now (release_now)
    );

    // Grants decode straight from the owner register.
    assign gnt_m0 = (owner == OWN_M0);
    assign gnt_m1 = (owner == OWN_M1);

endmodule

// File: rtl/arb_checker.sv
// Module: arb_checker
// Port-level properties of two_master_arbiter, attached with bind.
// Assumes: synchronous active-low reset; IDLE_GAP >= 1.
module arb_checker #(
    parameter int IDLE_GAP = 1
) (
    input logic clk,
    input logic rst_n,
    input logic req_m0,
    input logic req_m1,
    input logic gnt_m0,
    input logic gnt_m1
);

    localparam int QW = $clog2(IDLE_GAP + 1) + 1;

    logic [QW-1:0] quiet_q;

    // Count quiet cycles since the last grant, saturating at IDLE_GAP.
    always_ff @(posedge clk) begin
        if (!rst_n)
            quiet_q <= QW'(IDLE_GAP);
        else if (gnt_m0 || gnt_m1)
            quiet_q <= '0;
        else if (quiet_q < QW'(IDLE_GAP))
            quiet_q <= quiet_q + 1'b1;
    end

    a_r2_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(gnt_m0 && gnt_m1));

    a_r5_hold_m0: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_m0 && req_m0) |=> gnt_m0);

    a_r5_hold_m1: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_m1 && req_m1) |=> gnt_m1);

    a_r6_release_m0: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_m0 && !req_m0) |=> !gnt_m0);

    a_r6_release_m1: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_m1 && !req_m1) |=> !gnt_m1);

    a_r7_quiet_gap: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(gnt_m0) || $rose(gnt_m1)) |-> (quiet_q >= QW'(IDLE_GAP)));

    a_r8_rise_m0: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gnt_m0) |-> $past(req_m0));

    a_r8_rise_m1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gnt_m1) |-> $past(req_m1));

    a_r1_reset_clear: assert property (@(posedge clk)
        $past(!rst_n) |-> (!gnt_m0 && !gnt_m1));

endmodule

bind two_master_arbiter arb_checker #(.IDLE_GAP(IDLE_GAP)) u_arb_checker (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_m0 (req_m0),
    .req_m1 (req_m1),
    .gnt_m0 (gnt_m0),
    .gnt_m1 (gnt_m1)
);

// File: tb/tb_two_master_arbiter.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver computes expected grants from the
// requirements and queues them; the monitor compares at each falling edge.
module tb_two_master_arbiter;

    localparam int GAP = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req0 = 1'b0;
    logic req1 = 1'b0;
    logic gnt0;
    logic gnt1;

    int cyc = 0;
    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        int    due;
        logic  g0;
        logic  g1;
        string tag;
    } exp_t;

    exp_t sb_q[$];

    // Reference state kept from the requirements.
    int m_own = 0;
    int m_cnt = 0;

    two_master_arbiter #(.IDLE_GAP(GAP)) dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_m0 (req0),
        .req_m1 (req1),
        .gnt_m0 (gnt0),
        .gnt_m1 (gnt1)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Driver: apply one cycle of stimulus and queue the expected grants.
    task automatic step(input logic r0, input logic r1, input logic rs, input string tag);
        exp_t e;
        @(negedge clk);
        req0 = r0;
        req1 = r1;
        rst_n = rs;
        if (!rs) begin
            m_own = 0;
            m_cnt = 0;
        end else begin
            case (m_own)
                0: begin
                    if (m_cnt != 0) m_cnt = m_cnt - 1;
                    else if (r0) m_own = 1;
                    else if (r1) m_own = 2;
                end
                1: if (!r0) begin m_own = 0; m_cnt = GAP - 1; end
                default: if (!r1) begin m_own = 0; m_cnt = GAP - 1; end
            endcase
        end
        e.due = cyc + 1;
        e.g0 = (m_own == 1);
        e.g1 = (m_own == 2);
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic repeat_step(input int n, input logic r0, input logic r1, input string tag);
        for (int i = 0; i < n; i++) step(r0, r1, 1'b1, tag);
    endtask

    // Monitor: pop every item due now and compare with the ports.
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
            exp_t e;
            e = sb_q.pop_front();
            n_checks++;
            if (gnt0 !== e.g0 || gnt1 !== e.g1) begin
                n_fail++;
                $display("FAIL %s cycle %0d: grants got %b%b expected %b%b",
                         e.tag, cyc, gnt0, gnt1, e.g0, e.g1);
            end
            if (gnt0 === 1'b1 && gnt1 === 1'b1) begin
                n_fail++;
                $display("FAIL R2 cycle %0d: both grants high, expected at most one", cyc);
            end
        end
    end

    initial begin
        // R1: reset holds grants low even with requests up.
        step(1'b0, 1'b0, 1'b0, "R1");
        step(1'b1, 1'b1, 1'b0, "R1");
        step(1'b0, 1'b0, 1'b0, "R1");
        // R9: idle bus stays idle.
        repeat_step(3, 1'b0, 1'b0, "R9");
        // R3: master 1 alone on a free bus.
        step(1'b0, 1'b1, 1'b1, "R3");
        // R5: master 0 asks while master 1 owns; no preemption.
        repeat_step(3, 1'b1, 1'b1, "R5");
        // R6/R7: master 1 lets go; gap of GAP cycles, then master 0.
        step(1'b1, 1'b0, 1'b1, "R6");
        repeat_step(GAP, 1'b1, 1'b0, "R7");
        repeat_step(2, 1'b1, 1'b0, "R7");
        // R7: hand back to master 1 which waits across the gap.
        repeat_step(2, 1'b1, 1'b1, "R5");
        step(1'b0, 1'b1, 1'b1, "R6");
        repeat_step(GAP + 2, 1'b0, 1'b1, "R7");
        step(1'b0, 1'b0, 1'b1, "R6");
        repeat_step(GAP + 1, 1'b0, 1'b0, "R9");
        // R4: contention on a free bus goes to master 0.
        repeat_step(3, 1'b1, 1'b1, "R4");
        step(1'b0, 1'b1, 1'b1, "R6");
        repeat_step(GAP + 2, 1'b0, 1'b1, "R7");
        step(1'b0, 1'b0, 1'b1, "R6");
        repeat_step(GAP, 1'b0, 1'b0, "R9");
        // R8: a one-cycle pulse from master 1 yields a one-cycle grant.
        step(1'b0, 1'b1, 1'b1, "R8");
        repeat_step(GAP + 2, 1'b0, 1'b0, "R8");
        // R7: request arriving mid-gap waits for the gap to end.
        step(1'b1, 1'b0, 1'b1, "R3");
        step(1'b0, 1'b0, 1'b1, "R6");
        step(1'b0, 1'b1, 1'b1, "R7");
        repeat_step(GAP + 2, 1'b0, 1'b1, "R7");
        // R1: reset while master 1 owns the bus.
        step(1'b1, 1'b1, 1'b0, "R1");
        step(1'b1, 1'b1, 1'b1, "R4");
        repeat_step(2, 1'b1, 1'b1, "R5");
        step(1'b0, 1'b0, 1'b1, "R6");
        repeat_step(GAP + 1, 1'b0, 1'b0, "R9");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
    end

    // Finish on completion or on the watchdog.
    initial begin
        int waited;
        waited = 0;
        while (!done && waited < 5000) begin
            @(posedge clk);
            waited++;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule